// File: doc/BRIEF.md
# Tree-Structured 1:8 Deserializer

This block turns a serial bit stream, one bit per fast-clock cycle, into an eight-bit parallel word that updates once every eight fast cycles. The fast clock is divided in two steps: a divide-by-two phase toggle, then a divide-by-four counter. The bit stream follows the same tree. A full-rate 1:2 stage sorts each bit by the half-rate phase into an even stream and an odd stream. Two 1:4 stages then spread those streams into lanes. The even branch fills lanes 0, 2, 4 and 6, and the odd branch fills lanes 1, 3, 5 and 7. A single output register loads all eight lanes at once.

The block also drives a complementary word-clock pair at one eighth of the fast rate. The rising edge of the true phase falls on the same fast-clock edge as each output-word update, so a slower downstream domain can capture the word on that edge. A synchronous reset clears the dividers, the lane shifters and the output register. The first bit sampled after reset release becomes bit 0 of word 0, so reset also fixes the word boundary.

The divide-by-two step is a two-state machine. State HALF_EVEN always moves to HALF_ODD on the next edge, and HALF_ODD always moves back to HALF_EVEN. The bit slot within the word is formed from the quarter counter (upper bits) and this state (low bit). The quarter counter advances on each HALF_ODD to HALF_EVEN transition.

Top module: `deser_tree_1to8`

## Requirements
- R1: While reset is applied at a clock edge, the following cycle shows `q_out` = 0, `wclk_p` = 0 and `wclk_n` = 1.
- R2: Number bits from 0, with bit 0 being the `ser_in` value sampled at the first rising edge after reset release. Bit k goes to word k/8 and appears on `q_out[k mod 8]`: the first bit of a word on `q_out[0]`, the eighth on `q_out[7]`.
- R3: Word w appears on `q_out` immediately after fast edge 8w+9 (edges counted from 0 after release). It stays unchanged for eight cycles.
- R4: `q_out` changes only on an edge where `wclk_p` rises.
- R5: `wclk_n` is always the inverse of `wclk_p`. `wclk_p` is high for four cycles and low for four cycles, a period of eight fast cycles.
- R6: `wclk_p` rises after edges 1, 9, 17 and so on, counted from reset release. This is the same edge that loads a new word.
- R7: Until the first complete word is presented (before edge 9), `q_out` stays 0 even though the word clock already runs.
- R8: Reset applied in the middle of a word discards the partial word. After release, the next sampled bit is again bit 0 and lands on lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (bit-rate) clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data, one bit per fast cycle |
| q_out | output | LANES (8) | Parallel word, lane i carries the i-th bit of the word |
| wclk_p | output | 1 | Word clock, true phase, rises with each new word |
| wclk_n | output | 1 | Word clock, complement phase |

## Verification
The bench serializes known and random words into the block LSB first. Its scoreboard then expects each word back on the rising edge of the word clock, at exactly the position that R3 and R6 give. If the odd and even branches were swapped, or a 1:4 shifter ran in the wrong direction, the scoreboard would see lanes permuted. If the output register loaded one fast cycle early or late, it would capture a mix of two words, and the rise of the word clock would no longer match a data change. A reset in the middle of a word, followed by fresh words, catches a design that keeps the old slot count or leaks the discarded partial word. The bench also compares all-zero idle traffic and watches the first word-clock rise, where a design without the initial quiet period would present garbage.

// File: rtl/deser_pkg.sv
package deser_pkg;
    // Phase of the divide-by-two stage: which branch owns the current bit.
    typedef enum logic {
        HALF_EVEN = 1'b0,
        HALF_ODD  = 1'b1
    } half_e;

    localparam int unsigned BRANCHES = 2;
endpackage

// File: rtl/deser_div.sv
module deser_div
    import deser_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    output half_e                    half_q,
    output logic [$clog2(LANES)-1:0] slot,
    output logic                     wclk_p,
    output logic                     wclk_n
);
    localparam int unsigned SLOT_W = $clog2(LANES);
    localparam int unsigned QTR_W  = SLOT_W - 1;
    localparam int unsigned HIGH_LAST = LANES / 2;

    half_e              half_d;
    logic [QTR_W-1:0]   quarter;

    // State register of the divide-by-two machine.
    always_ff @(posedge clk) begin
        if (rst) half_q <= HALF_EVEN;
        else     half_q <= half_d;
    end

    // Next-state logic.
    always_comb begin
        unique case (half_q)
            HALF_EVEN: half_d = HALF_ODD;
            HALF_ODD:  half_d = HALF_EVEN;
            default:   half_d = HALF_EVEN;
        endcase
    end

    // Divide-by-four stage, advanced on the HALF_ODD -> HALF_EVEN transition.
    always_ff @(posedge clk) begin
        if (rst)                   quarter <= '0;
        else if (half_q == HALF_ODD) quarter <= quarter + 1'b1;
    end

    assign slot = {quarter, half_q};

    // Word clock outputs, high for slots 1..LANES/2 of the previous edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            wclk_p <= 1'b0;
            wclk_n <= 1'b1;
        end else begin
            wclk_p <=  ((slot >= SLOT_W'(1)) && (slot <= SLOT_W'(HIGH_LAST)));
            wclk_n <= ~((slot >= SLOT_W'(1)) && (slot <= SLOT_W'(HIGH_LAST)));
        end
    end

    // R5: the half-rate phase must alternate every fast cycle.
    assert_half_toggle_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (half_q != $past(half_q)));

    // R5: the two word-clock phases stay complementary.
    assert_wclk_complement_R5: assert property (@(posedge clk) disable iff (rst)
        wclk_n == ~wclk_p);
endmodule

// File: rtl/deser_split2.sv
module deser_split2
    import deser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ser_in,
    input  half_e phase,
    output logic  even_bit,
    output logic  odd_bit
);
    // Full-rate 1:2 split: each bit is parked in the register of its phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            even_bit <= 1'b0;
            odd_bit  <= 1'b0;
        end else begin
            unique case (phase)
                HALF_EVEN: even_bit <= ser_in;
                HALF_ODD:  odd_bit  <= ser_in;
                default:   even_bit <= ser_in;
            endcase
        end
    end

    // R2: even-phase bits are captured into the even stream.
    assert_even_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == HALF_EVEN) |=> (even_bit == $past(ser_in)));

    // R2: odd-phase bits are captured into the odd stream.
    assert_odd_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == HALF_ODD) |=> (odd_bit == $past(ser_in)));
endmodule

// File: rtl/deser_split4.sv
module deser_split4 #(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [DEPTH-1:0] lanes
);
    // Half-rate 1:DEPTH split: newest bit enters at the top, oldest ends at lane 0.
    always_ff @(posedge clk) begin
        if (rst)           lanes <= '0;
        else if (shift_en) lanes <= {bit_in, lanes[DEPTH-1:1]};
    end

    // R2: a disabled shifter holds its lanes.
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(lanes));
endmodule

// File: rtl/deser_tree_1to8.sv
module deser_tree_1to8
    import deser_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    output logic [LANES-1:0] q_out,
    output logic             wclk_p,
    output logic             wclk_n
);
    localparam int unsigned SLOT_W     = $clog2(LANES);
    localparam int unsigned PER_BRANCH = LANES / BRANCHES;

    half_e              half_q;
    logic [SLOT_W-1:0]  slot;
    logic               even_bit;
    logic               odd_bit;
    logic [PER_BRANCH-1:0] branch_lanes [BRANCHES];
    logic [LANES-1:0]   word_d;
    logic               primed;

    deser_div #(.LANES(LANES)) u_div (
        .clk    (clk),
        .rst    (rst),
        .half_q (half_q),
        .slot   (slot),
        .wclk_p (wclk_p),
        .wclk_n (wclk_n)
    );

    deser_split2 u_split2 (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .phase    (half_q),
        .even_bit (even_bit),
        .odd_bit  (odd_bit)
    );

    // Each branch shifts one cycle after its bit was parked by the 1:2 stage.
    for (genvar b = 0; b < BRANCHES; b++) begin : g_branch
        deser_split4 #(.DEPTH(PER_BRANCH)) u_split4 (
            .clk      (clk),
            .rst      (rst),
            .shift_en ((b == 0) ? (half_q == HALF_ODD) : (half_q == HALF_EVEN)),
            .bit_in   ((b == 0) ? even_bit : odd_bit),
            .lanes    (branch_lanes[b])
        );
    end

    // Interleave: even branch feeds even lanes, odd branch feeds odd lanes.
    for (genvar i = 0; i < PER_BRANCH; i++) begin : g_lane
        assign word_d[2*i]   = branch_lanes[0][i];
        assign word_d[2*i+1] = branch_lanes[1][i];
    end

    // First word is complete once the last slot has been sampled.
    always_ff @(posedge clk) begin
        if (rst)                               primed <= 1'b0;
        else if (slot == SLOT_W'(LANES - 1))  primed <= 1'b1;
    end

    // Output word register, loaded in slot 1 when the odd branch has its last bit.
    always_ff @(posedge clk) begin
        if (rst)                                  q_out <= '0;
        else if (primed && (slot == SLOT_W'(1))) q_out <= word_d;
    end

    // R1: reset clears the output word.
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (q_out == '0));

    // R4: the word changes only together with a word-clock rise.
    assert_update_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !$rose(wclk_p) |-> $stable(q_out));

    // R7: nothing is presented before the first full word.
    assert_quiet_until_first_R7: assert property (@(posedge clk) disable iff (rst)
        !primed |-> (q_out == '0));
endmodule

// File: tb/tb_deser_tree_1to8.sv
module tb_deser_tree_1to8;
    localparam int LANES = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ser_in = 1'b0;
    logic [LANES-1:0] q_out;
    logic             wclk_p;
    logic             wclk_n;

    int          checks = 0;
    int          failures = 0;
    int          ecount = 0;
    logic        rst_seen = 1'b0;
    logic        edge_seen = 1'b0;
    logic        prev_wp = 1'b0;
    int          hi_run = 0;
    logic [7:0]  last_q = '0;
    logic [7:0]  exp_w;
    logic [7:0]  exp_q [$];
    string       tag = "R2 R3";

    deser_tree_1to8 #(.LANES(LANES)) dut (
        .clk    (clk),
        .rst    (rst),
        .ser_in (ser_in),
        .q_out  (q_out),
        .wclk_p (wclk_p),
        .wclk_n (wclk_n)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Edge counter since reset release and reset as seen by the design.
    always @(posedge clk) begin
        edge_seen <= 1'b1;
        rst_seen  <= rst;
        if (rst) ecount <= 0;
        else     ecount <= ecount + 1;
    end

    // Monitor: samples on the falling edge, pops expected words on word-clock rises.
    always @(negedge clk) begin
        if (edge_seen) begin
            if (rst_seen) begin
                // R1
                check(q_out == 8'h00 && wclk_p == 1'b0 && wclk_n == 1'b1, "R1",
                      {q_out[7:2], wclk_p, wclk_n}, 8'h01);
                prev_wp = 1'b0;
                hi_run  = 0;
                last_q  = '0;
            end else begin
                // R5: complementary phases
                check(wclk_n == ~wclk_p, "R5", {7'b0, wclk_n}, {7'b0, ~wclk_p});
                if (wclk_p && !prev_wp) begin
                    // R6: rise position within the word
                    check((ecount % 8) == 2, "R6", 8'(ecount % 8), 8'd2);
                    if (ecount < 10) begin
                        // R7: quiet until first full word
                        check(q_out == 8'h00, "R7", q_out, 8'h00);
                    end else begin
                        exp_w = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
                        check(q_out == exp_w, tag, q_out, exp_w);
                    end
                end else begin
                    // R4: no change away from a rise
                    check(q_out == last_q, "R4", q_out, last_q);
                end
                if (!wclk_p && prev_wp) begin
                    // R5: high time of four cycles
                    check(hi_run == 4, "R5", 8'(hi_run), 8'd4);
                    hi_run = 0;
                end
                if (wclk_p) hi_run++;
                prev_wp = wclk_p;
                last_q  = q_out;
            end
        end
    end

    task automatic send_word(input logic [7:0] w);
        exp_q.push_back(w);
        for (int j = 0; j < 8; j++) begin
            ser_in = w[j];
            @(posedge clk);
            #2;
        end
    endtask

    task automatic idle(input int n);
        ser_in = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #2;
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R2 R3: directed lane patterns, then random words
        send_word(8'h01);
        send_word(8'h80);
        send_word(8'hFF);
        send_word(8'h00);
        send_word(8'h55);
        send_word(8'hAA);
        for (int n = 0; n < 20; n++) send_word(8'($urandom));
        idle(24);
        // R8: reset in the middle of a word
        ser_in = 1'b1;
        repeat (3) begin
            @(posedge clk);
            #2;
        end
        rst = 1'b1;
        exp_q.delete();
        tag = "R8";
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        send_word(8'hC3);
        send_word(8'h3C);
        for (int n = 0; n < 10; n++) send_word(8'($urandom));
        idle(24);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R3 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule